// File: doc/BRIEF.md
# Auto Wake/Sleep Power-Mode Controller

This block decides which sampling mode a sampled sensor runs in. It has three modes. In standby nothing is sampled. In wake the sensor samples at a fast, selectable rate. In sleep it drops to a slow rate to save current. The block is told when each sample is taken through a one-cycle strobe. It counts inactivity in fixed time steps and drops from wake to sleep once the programmed timeout has passed with no qualifying event. It returns to wake when an event source that is both enabled and selected for wake fires. The data rate and oversampling selects that the datapath should use are driven from the current mode.

Six event sources arrive as one-cycle flags at fixed bit positions: bit 0 motion/freefall, bit 1 tap, bit 2 orientation, bit 3 transient, bit 4 FIFO gate, bit 5 data-ready. Each source has its own enable bit and wake-select bit. A fixed rule per source decides whether the source holds off sleep and whether it can end it. A sticky flag marks every change between wake and sleep. A host read of the mode status clears it. All control and status pins are plain levels or strobes. No pin carries a data stream, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `aws_ctrl`

## Requirements
- R1: The mode output codes standby as 00, wake as 01 and sleep as 10, and never shows 11. After reset the mode is standby and the mode-change flag is 0.
- R2: With the active input low, the mode is standby one cycle later. With active high in standby, the mode is wake one cycle later.
- R3: With the sleep-enable input low the block never enters sleep. If sleep-enable falls while in sleep, the mode is wake one cycle later.
- R4: In wake with sleep-enable high, sample strobes are grouped into timeout steps. A step is 256, 128, 64, 32, 16, 4, 2 or 1 strobes for wake rate codes 0 to 7, which is 320 ms per step for codes 0 to 6 and 640 ms for code 7. The block enters sleep on the strobe that completes step number timeout+1 with no qualifying event, so a timeout of 0 means one step.
- R5: The rate output equals the 3-bit wake rate select in standby and wake. In sleep it is {1, sleep_rate}, so the 2-bit sleep codes 00/01/10/11 (50/12.5/6.25/1.56 Hz) map to the wake-table codes 100/101/110/111.
- R6: The oversampling output equals the wake oversampling select in standby and wake, and the sleep oversampling select in sleep. The codes are 00 normal, 01 low-noise low-power, 10 high-resolution, 11 low-power.
- R7: An enabled event on any of bits 0 to 4 restarts the inactivity count from zero. A disabled event, or any event on bit 5, leaves the count running.
- R8: In sleep, an event on bits 0 to 3 whose enable and wake-select bits are both set gives wake one cycle later. Events on bit 4 or bit 5 never wake the block, whatever the masks hold.
- R9: Each wake-to-sleep or sleep-to-wake change sets the mode-change flag. A status-read strobe clears it. A change in the same cycle as a read leaves the flag set.
- R10: With no enabled source selected for wake, the block stays in sleep for any number of strobes and events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle strobe per sample at the current rate |
| active | input | 1 | Run request; low forces standby |
| sleep_en | input | 1 | Allows automatic entry into sleep |
| wake_rate | input | 3 | Wake data-rate select (000=800 Hz to 111=1.56 Hz) |
| sleep_rate | input | 2 | Sleep data-rate select (00=50 Hz to 11=1.56 Hz) |
| wake_osr | input | 2 | Oversampling select used outside sleep |
| sleep_osr | input | 2 | Oversampling select used in sleep |
| timeout | input | 8 | Inactivity timeout in steps, minus one |
| evt | input | 6 | Per-source event strobes |
| evt_en | input | 6 | Per-source enable mask |
| wake_sel | input | 6 | Per-source wake-select mask |
| status_rd | input | 1 | Mode status read strobe; clears the change flag |
| sys_mode | output | 2 | Current mode code |
| odr_sel | output | 3 | Rate select in effect |
| osr_sel | output | 2 | Oversampling select in effect |
| mode_chg | output | 1 | Sticky wake/sleep change flag |

## Verification
Mode, flag and counter changes take one register stage. A condition present at a clock edge shows on sys_mode and mode_chg right after that edge. The rate and oversampling outputs follow the registered mode and the select inputs combinationally, with no added delay. The bench drives inputs just after each rising edge. It steps a behavioural model at the rising edge and compares all four outputs at the falling edge of every cycle. Directed checks sample one time unit after the edge that takes the last strobe or event of a sequence. For example, with a 4-strobe step and a timeout of 1, wake must still hold after 7 strobes and sleep must show after the 8th.

// File: rtl/aws_pkg.sv
package aws_pkg;
  typedef enum logic [1:0] {
    MODE_STBY  = 2'b00,
    MODE_WAKE  = 2'b01,
    MODE_SLEEP = 2'b10
  } mode_e;

  localparam int NSRC  = 6;
  localparam int PRE_W = 9;

  // Source positions: 0 motion, 1 tap, 2 orientation, 3 transient, 4 fifo gate, 5 data-ready
  localparam logic [NSRC-1:0] HOLD_CAP = 6'b011111;
  localparam logic [NSRC-1:0] WAKE_CAP = 6'b001111;

  // Strobes per timeout step at a given wake rate code
  function automatic logic [PRE_W-1:0] step_ticks(input logic [2:0] rate);
    logic [PRE_W-1:0] r;
    case (rate)
      3'd0: r = 9'd256;
      3'd1: r = 9'd128;
      3'd2: r = 9'd64;
      3'd3: r = 9'd32;
      3'd4: r = 9'd16;
      3'd5: r = 9'd4;
      3'd6: r = 9'd2;
      default: r = 9'd1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/aws_event_qual.sv
module aws_event_qual #(
  parameter int N = 6,
  parameter logic [N-1:0] HOLD = '1,
  parameter logic [N-1:0] WAKE = '1
) (
  input  logic [N-1:0] evt,
  input  logic [N-1:0] evt_en,
  input  logic [N-1:0] wake_sel,
  output logic         hold_hit,
  output logic         wake_hit
);
  logic [N-1:0] hold_v, wake_v;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign hold_v[i] = evt[i] & evt_en[i] & HOLD[i];
    assign wake_v[i] = evt[i] & evt_en[i] & wake_sel[i] & WAKE[i];
  end

  assign hold_hit = |hold_v;
  assign wake_hit = |wake_v;
endmodule

// File: rtl/aws_inact_timer.sv
module aws_inact_timer #(
  parameter int TO_W  = 8,
  parameter int PRE_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [PRE_W-1:0] limit,
  input  logic [TO_W-1:0]  timeout,
  output logic             expire
);
  localparam logic [PRE_W-1:0] ONE_P = PRE_W'(1);
  localparam logic [TO_W-1:0]  ONE_S = TO_W'(1);

  logic [PRE_W-1:0] pre_q;
  logic [TO_W-1:0]  steps_q;
  logic             wrap;

  assign wrap   = tick && (pre_q == limit - ONE_P);
  assign expire = run && !restart && wrap && (steps_q == timeout);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart || expire) begin
      pre_q   <= '0;
      steps_q <= '0;
    end else if (tick) begin
      if (wrap) begin
        pre_q   <= '0;
        steps_q <= steps_q + ONE_S;
      end else begin
        pre_q <= pre_q + ONE_P;
      end
    end
  end

  // R7: a qualifying event leaves the count at zero on the next cycle
  p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0 && steps_q == '0));

  // R4: the count never runs while the timer is idle
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0 && steps_q == '0));
endmodule

// File: rtl/aws_mode_fsm.sv
module aws_mode_fsm
  import aws_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  input  logic  sleep_en,
  input  logic  expire,
  input  logic  wake_hit,
  input  logic  status_rd,
  output mode_e mode,
  output logic  chg_flag
);
  mode_e nxt;
  logic  swap;

  always_comb begin
    nxt = mode;
    if (!active) begin
      nxt = MODE_STBY;
    end else begin
      case (mode)
        MODE_STBY:  nxt = MODE_WAKE;
        MODE_WAKE:  if (sleep_en && expire) nxt = MODE_SLEEP;
        MODE_SLEEP: if (!sleep_en || wake_hit) nxt = MODE_WAKE;
        default:    nxt = MODE_STBY;
      endcase
    end
  end

  assign swap = ((mode == MODE_WAKE) && (nxt == MODE_SLEEP)) ||
                ((mode == MODE_SLEEP) && (nxt == MODE_WAKE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MODE_STBY;
      chg_flag <= 1'b0;
    end else begin
      mode <= nxt;
      if (swap)           chg_flag <= 1'b1;
      else if (status_rd) chg_flag <= 1'b0;
    end
  end

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> mode == MODE_STBY);

  p_no_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_en |=> mode != MODE_SLEEP);

  p_flag_on_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != mode && $past(mode) != MODE_STBY && mode != MODE_STBY) |-> chg_flag);

  p_stay_asleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLEEP && active && sleep_en && !wake_hit) |=> mode == MODE_SLEEP);
endmodule

// File: rtl/aws_ctrl.sv
module aws_ctrl
  import aws_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_tick,
  input  logic            active,
  input  logic            sleep_en,
  input  logic [2:0]      wake_rate,
  input  logic [1:0]      sleep_rate,
  input  logic [1:0]      wake_osr,
  input  logic [1:0]      sleep_osr,
  input  logic [TO_W-1:0] timeout,
  input  logic [5:0]      evt,
  input  logic [5:0]      evt_en,
  input  logic [5:0]      wake_sel,
  input  logic            status_rd,
  output logic [1:0]      sys_mode,
  output logic [2:0]      odr_sel,
  output logic [1:0]      osr_sel,
  output logic            mode_chg
);
  mode_e mode;
  logic  hold_hit, wake_hit, expire, run;
  logic  in_sleep;

  aws_event_qual #(.N(NSRC), .HOLD(HOLD_CAP), .WAKE(WAKE_CAP)) u_qual (
    .evt      (evt),
    .evt_en   (evt_en),
    .wake_sel (wake_sel),
    .hold_hit (hold_hit),
    .wake_hit (wake_hit)
  );

  assign run = (mode == MODE_WAKE) && sleep_en && active;

  aws_inact_timer #(.TO_W(TO_W), .PRE_W(PRE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (hold_hit),
    .tick    (sample_tick),
    .limit   (step_ticks(wake_rate)),
    .timeout (timeout),
    .expire  (expire)
  );

  aws_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .sleep_en  (sleep_en),
    .expire    (expire),
    .wake_hit  (wake_hit),
    .status_rd (status_rd),
    .mode      (mode),
    .chg_flag  (mode_chg)
  );

  assign in_sleep = (mode == MODE_SLEEP);
  assign sys_mode = mode;
  assign odr_sel  = in_sleep ? {1'b1, sleep_rate} : wake_rate;
  assign osr_sel  = in_sleep ? sleep_osr : wake_osr;

  // R8: a sleep that ends while active and enabled needs a wake-capable event
  p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLEEP && active && sleep_en && !wake_hit) |=> sys_mode == 2'b10);
endmodule

// File: tb/sim_aws_ctrl.sv
`timescale 1ns/1ps
module sim_aws_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0, active = 1'b0, sleep_en = 1'b0, status_rd = 1'b0;
  logic [2:0] wake_rate = 3'd0;
  logic [1:0] sleep_rate = 2'd0, wake_osr = 2'd0, sleep_osr = 2'd0;
  logic [7:0] timeout = 8'd0;
  logic [5:0] evt = '0, evt_en = '0, wake_sel = '0;
  logic [1:0] sys_mode, osr_sel;
  logic [2:0] odr_sel;
  logic mode_chg;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  aws_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .active(active),
    .sleep_en(sleep_en), .wake_rate(wake_rate), .sleep_rate(sleep_rate),
    .wake_osr(wake_osr), .sleep_osr(sleep_osr), .timeout(timeout),
    .evt(evt), .evt_en(evt_en), .wake_sel(wake_sel), .status_rd(status_rd),
    .sys_mode(sys_mode), .odr_sel(odr_sel), .osr_sel(osr_sel), .mode_chg(mode_chg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 standby, 1 wake, 2 sleep
  int  m_mode = 0, m_cnt = 0, m_steps = 0;
  bit  m_flag = 0;
  int  nm, lim;
  bit  hold, wk, done;

  function automatic int per_step(input int r);
    if (r < 5) return 256 / (1 << r);
    if (r == 5) return 4;
    if (r == 6) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_steps = 0; m_flag = 0;
    end else begin
      hold = 0; wk = 0; done = 0;
      for (int i = 0; i < 6; i++) begin
        if (evt[i] && evt_en[i]) begin
          if (i <= 4) hold = 1;
          if (i <= 3 && wake_sel[i]) wk = 1;
        end
      end
      lim = per_step(int'(wake_rate));
      if (m_mode == 1 && sleep_en && active) begin
        if (hold) begin
          m_cnt = 0; m_steps = 0;
        end else if (sample_tick) begin
          m_cnt++;
          if (m_cnt == lim) begin
            m_cnt = 0;
            if (m_steps == int'(timeout)) begin done = 1; m_steps = 0; end
            else m_steps++;
          end
        end
      end else begin
        m_cnt = 0; m_steps = 0;
      end
      if (!active) nm = 0;
      else if (m_mode == 0) nm = 1;
      else if (m_mode == 1) nm = done ? 2 : 1;
      else nm = (!sleep_en || wk) ? 1 : 2;
      if ((m_mode == 1 && nm == 2) || (m_mode == 2 && nm == 1)) m_flag = 1;
      else if (status_rd) m_flag = 0;
      m_mode = nm;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(sys_mode) == m_mode, "R1 mode vs model", sys_mode, m_mode);
      chk(mode_chg == m_flag, "R9 flag vs model", mode_chg, m_flag);
      chk(int'(odr_sel) == (m_mode == 2 ? 4 + int'(sleep_rate) : int'(wake_rate)),
          "R5 rate vs model", odr_sel, (m_mode == 2 ? 4 + int'(sleep_rate) : int'(wake_rate)));
      chk(osr_sel == (m_mode == 2 ? sleep_osr : wake_osr), "R6 osr vs model",
          osr_sel, (m_mode == 2 ? sleep_osr : wake_osr));
    end
  end

  task automatic ticks(input int n);
    @(posedge clk); #1 sample_tick = 1'b1;
    repeat (n - 1) @(posedge clk);
    @(posedge clk); #1 sample_tick = 1'b0;
  endtask

  task automatic pulse_evt(input logic [5:0] v);
    @(posedge clk); #1 evt = v;
    @(posedge clk); #1 evt = '0;
  endtask

  task automatic read_status();
    @(posedge clk); #1 status_rd = 1'b1;
    @(posedge clk); #1 status_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wake_osr = 2'b10; sleep_osr = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    chk(sys_mode == 2'b00, "R1 reset mode", sys_mode, 0);
    chk(mode_chg == 1'b0, "R1 reset flag", mode_chg, 0);
    rst_n = 1'b1;
    @(posedge clk); #1 active = 1'b1;
    @(posedge clk); #1;
    chk(sys_mode == 2'b01, "R2 standby to wake", sys_mode, 1);

    // R3: no sleep without enable
    wake_rate = 3'd7; timeout = 8'd0;
    ticks(40);
    chk(sys_mode == 2'b01, "R3 no sleep when disabled", sys_mode, 1);

    // R4: 1-strobe steps, timeout 3 -> sleep on 4th strobe
    @(posedge clk); #1 sleep_en = 1'b1; timeout = 8'd3; sleep_rate = 2'd2;
    ticks(3);
    chk(sys_mode == 2'b01, "R4 before expiry", sys_mode, 1);
    ticks(1);
    chk(sys_mode == 2'b10, "R4 expiry", sys_mode, 2);
    chk(mode_chg == 1'b1, "R9 flag on sleep", mode_chg, 1);
    chk(odr_sel == 3'b110, "R5 sleep rate", odr_sel, 6);
    chk(osr_sel == 2'b11, "R6 sleep osr", osr_sel, 3);
    read_status();
    chk(mode_chg == 1'b0, "R9 cleared by read", mode_chg, 0);

    // R8/R10: non-waking events while asleep
    evt_en = 6'b111111; wake_sel = 6'b110000;
    pulse_evt(6'b010000);
    pulse_evt(6'b100000);
    pulse_evt(6'b001111);
    ticks(20);
    chk(sys_mode == 2'b10, "R10 stays asleep", sys_mode, 2);
    chk(mode_chg == 1'b0, "R8 fifo/drdy no wake", mode_chg, 0);

    // R8: tap with wake-select wakes; configure for next phase while asleep
    wake_rate = 3'd5; timeout = 8'd1; wake_sel = 6'b000010;
    pulse_evt(6'b000010);
    chk(sys_mode == 2'b01, "R8 tap wakes", sys_mode, 1);
    chk(mode_chg == 1'b1, "R9 flag on wake", mode_chg, 1);
    chk(odr_sel == 3'd5, "R5 wake rate", odr_sel, 5);
    read_status();

    // R7: enabled tap restarts the 8-strobe window
    ticks(6);
    pulse_evt(6'b000010);
    ticks(7);
    chk(sys_mode == 2'b01, "R7 restart delays sleep", sys_mode, 1);
    ticks(1);
    chk(sys_mode == 2'b10, "R7 sleep after restart", sys_mode, 2);

    // R7: disabled and data-ready events do not restart
    pulse_evt(6'b000010);
    chk(sys_mode == 2'b01, "R8 wake again", sys_mode, 1);
    evt_en = 6'b111101;
    ticks(5);
    pulse_evt(6'b000010);
    pulse_evt(6'b100000);
    ticks(3);
    chk(sys_mode == 2'b10, "R7 ignored events no restart", sys_mode, 2);

    // R4: rate 0, timeout 0 -> 256 strobes
    evt_en = 6'b111111;
    wake_rate = 3'd0; timeout = 8'd0;
    pulse_evt(6'b000010);
    ticks(255);
    chk(sys_mode == 2'b01, "R4 rate0 before", sys_mode, 1);
    ticks(1);
    chk(sys_mode == 2'b10, "R4 rate0 expiry", sys_mode, 2);
    read_status();

    // R3: disabling sleep while asleep returns to wake
    @(posedge clk); #1 sleep_en = 1'b0;
    @(posedge clk); #1;
    chk(sys_mode == 2'b01, "R3 disable returns wake", sys_mode, 1);
    chk(mode_chg == 1'b1, "R9 flag on forced wake", mode_chg, 1);

    // R9: change and read together keep the flag set
    read_status();
    @(posedge clk); #1 sleep_en = 1'b1; wake_rate = 3'd7;
    ticks(1);
    @(posedge clk); #1 status_rd = 1'b1; evt = 6'b000010;
    @(posedge clk); #1 status_rd = 1'b0; evt = '0;
    chk(mode_chg == 1'b1, "R9 set wins over read", mode_chg, 1);

    // R2: active low forces standby
    @(posedge clk); #1 active = 1'b0;
    @(posedge clk); #1;
    chk(sys_mode == 2'b00, "R2 standby", sys_mode, 0);
    chk(odr_sel == 3'd7 && osr_sel == 2'b10, "R6 standby selects", osr_sel, 2);

    repeat (3) @(posedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule